// File: doc/BRIEF.md
# Peripheral Access Control Unit

This unit holds the access-control state that a bus fabric consults before letting masters reach on-chip peripherals. It has one privilege register, with a bit per bus master, and a bank of peripheral control registers. Each of these registers has two 4-bit halves, and each half is a 3-bit access code plus a sticky lock bit. All of this state sits behind a simple single-cycle register bus. Every request carries the ID of the master that issued it. Any master may read. Only trusted masters may write, and a write that would alter a locked half is refused. A refused write is not silently dropped: it ends with an error response.

The unit also resolves, for every master, the effective privilege attribute that the fabric should use. When a master's privilege bit is clear, that master is forced to user mode. When the bit is set, the master's own supervisor attribute passes through unchanged. Master 0 is the processor. It is always trusted, and its privilege bit comes out of reset set. Decoding peripheral addresses and enforcing the access codes on real peripheral traffic are left to the fabric.

Top module: `periph_guard`

## Requirements
- R1: After reset the privilege register reads 0x01, all peripheral control registers read 0x00, and `rsp_ack` and `rsp_err` are low.
- R2: A request sampled with `req_valid` high gives `rsp_ack` high for exactly the next cycle. A cycle with no request gives `rsp_ack` low and `rsp_err` low in the following cycle.
- R3: A read from any master, trusted or not, never raises `rsp_err`. It returns the current register value on `rsp_rdata` in the acknowledge cycle. `rsp_rdata` is 0 in all other cycles.
- R4: A write from a master whose bit in `TRUST_MASK` is clear is refused. Master 0 is always trusted, and by default masters 0 and 1 are trusted. A refused write raises `rsp_err` together with `rsp_ack` and changes no register.
- R5: Address 0 selects the privilege register. Addresses 1 to 10 select peripheral control registers 0 to 9. A trusted, unblocked write stores all 8 bits. Bit 7 is the upper lock, bits 6:4 are the upper access code, bit 3 is the lower lock and bits 2:0 are the lower access code.
- R6: If a half's lock bit is set, a write that would change any of that half's four bits is refused with `rsp_err`, and the whole register stays unchanged.
- R7: A write that leaves every locked half bit-for-bit identical is accepted, and the unlocked half is updated.
- R8: A single write that sets a lock bit and changes the access code of the same half takes effect in full. The lock applies only to later writes.
- R9: A lock bit that has been set stays set through any number of write attempts. Only reset clears it, after which the half is writable again.
- R10: `mst_super_eff_o[m]` equals `mst_super_i[m]` when privilege bit m is 1, and it is 0 when privilege bit m is 0.
- R11: A write to an unmapped address (11 to 15) is refused with `rsp_err` and changes nothing. A read of an unmapped address returns 0 without error.
- R12: A write to the privilege register stores bits 3:0 only. Bits 7:4 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Register address |
| req_wdata | input | 8 | Write data |
| req_master | input | 2 | ID of the requesting master |
| rsp_ack | output | 1 | Request completed (one cycle after the request) |
| rsp_err | output | 1 | Write refused (with rsp_ack) |
| rsp_rdata | output | 8 | Read data in the acknowledge cycle |
| mst_super_i | input | 4 | Each master's own supervisor attribute |
| mst_super_eff_o | output | 4 | Effective supervisor attribute per master |

## Verification
The assertions assume that every request field is a known value whenever `req_valid` is high, and that there is at most one request per cycle with no back-pressure. They also assume the master ID is always within the configured number of masters. The bench changes every input only at the falling clock edge, one request per cycle, using IDs 0 to 3 and a 4-bit address. That keeps each request stable across the sampling edge, and it still reaches the unmapped addresses on purpose. Resets are applied between requests, so the lock-stickiness and no-change properties are checked only over stretches where reset is inactive, which is the condition they take for granted.

// File: rtl/pguard_pkg.sv
package pguard_pkg;

  localparam int CTRL_W = 3;
  localparam int REG_W  = 8;

  typedef struct packed {
    logic              lock;
    logic [CTRL_W-1:0] code;
  } half_t;

  // Upper half occupies bits 7:4, lower half bits 3:0.
  typedef struct packed {
    half_t hi;
    half_t lo;
  } pctl_t;

  typedef enum logic [1:0] {
    TGT_NONE   = 2'd0,
    TGT_PRIV   = 2'd1,
    TGT_PERIPH = 2'd2
  } tgt_e;

  // A locked half refuses any write that would alter one of its bits.
  function automatic logic half_blocked(half_t cur, half_t nxt);
    return cur.lock && (cur != nxt);
  endfunction

  function automatic logic write_blocked(pctl_t cur, pctl_t nxt);
    return half_blocked(cur.hi, nxt.hi) || half_blocked(cur.lo, nxt.lo);
  endfunction

  // Effective supervisor attribute: pass-through when enabled, user otherwise.
  function automatic logic resolve_super(logic enable, logic attr);
    return enable ? attr : 1'b0;
  endfunction

endpackage

// File: rtl/pguard_decode.sv
module pguard_decode
  import pguard_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int NUM_REGS    = 10,
  parameter int ADDR_W      = 4,
  parameter logic [NUM_MASTERS-1:0] TRUST_MASK = 'b0011,
  localparam int MID_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [MID_W-1:0]  master,
  output tgt_e              tgt,
  output logic [IDX_W-1:0]  idx,
  output logic              trusted
);

  localparam logic [NUM_MASTERS-1:0] TRUSTED = TRUST_MASK | NUM_MASTERS'(1);

  always_comb begin
    tgt = TGT_NONE;
    idx = '0;
    if (addr == '0) begin
      tgt = TGT_PRIV;
    end else if (int'(addr) <= NUM_REGS) begin
      tgt = TGT_PERIPH;
      idx = IDX_W'(int'(addr) - 1);
    end
  end

  assign trusted = TRUSTED[master];

endmodule

// File: rtl/pguard_gate.sv
module pguard_gate
  import pguard_pkg::*;
(
  input  logic  req_valid,
  input  logic  req_write,
  input  tgt_e  tgt,
  input  logic  trusted,
  input  pctl_t cur_sel,
  input  pctl_t wdata,
  output logic  commit_prv,
  output logic  commit_pctl,
  output logic  reject
);

  logic wr_req;
  logic locked_hit;

  assign wr_req     = req_valid && req_write;
  assign locked_hit = (tgt == TGT_PERIPH) && write_blocked(cur_sel, wdata);

  assign commit_prv  = wr_req && trusted && (tgt == TGT_PRIV);
  assign commit_pctl = wr_req && trusted && (tgt == TGT_PERIPH) && !locked_hit;
  assign reject      = wr_req && (!trusted || (tgt == TGT_NONE) || locked_hit);

endmodule

// File: rtl/pguard_store.sv
module pguard_store
  import pguard_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int NUM_REGS    = 10,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   commit_prv,
  input  logic                   commit_pctl,
  input  logic [IDX_W-1:0]       idx,
  input  logic [REG_W-1:0]       wdata,
  output logic [NUM_MASTERS-1:0] prv_q,
  output pctl_t [NUM_REGS-1:0]   pctl_q,
  output pctl_t                  sel_val
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          prv_q <= NUM_MASTERS'(1);
    else if (commit_prv) prv_q <= wdata[NUM_MASTERS-1:0];
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 pctl_q[g] <= '0;
      else if (commit_pctl && idx == IDX_W'(g))   pctl_q[g] <= pctl_t'(wdata);
    end
  end

  always_comb begin
    sel_val = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (idx == IDX_W'(i)) sel_val = pctl_q[i];
  end

endmodule

// File: rtl/pguard_priv.sv
module pguard_priv
  import pguard_pkg::*;
#(
  parameter int NUM_MASTERS = 4
) (
  input  logic [NUM_MASTERS-1:0] prv_q,
  input  logic [NUM_MASTERS-1:0] attr,
  output logic [NUM_MASTERS-1:0] eff
);

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_mst
    assign eff[m] = resolve_super(prv_q[m], attr[m]);
  end

endmodule

// File: rtl/periph_guard.sv
module periph_guard
  import pguard_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int NUM_REGS    = 10,
  parameter int ADDR_W      = 4,
  parameter logic [NUM_MASTERS-1:0] TRUST_MASK = 'b0011,
  localparam int MID_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [REG_W-1:0]       req_wdata,
  input  logic [MID_W-1:0]       req_master,
  output logic                   rsp_ack,
  output logic                   rsp_err,
  output logic [REG_W-1:0]       rsp_rdata,
  input  logic [NUM_MASTERS-1:0] mst_super_i,
  output logic [NUM_MASTERS-1:0] mst_super_eff_o
);

  tgt_e                    tgt;
  logic [IDX_W-1:0]        idx;
  logic                    trusted;
  logic                    commit_prv;
  logic                    commit_pctl;
  logic                    wr_reject;
  logic                    wr_commit;
  logic [NUM_MASTERS-1:0]  prv_q;
  pctl_t [NUM_REGS-1:0]    pctl_q;
  pctl_t                   sel_val;
  logic [NUM_REGS*REG_W-1:0] pctl_flat;
  logic [REG_W-1:0]        rd_val;

  pguard_decode #(
    .NUM_MASTERS(NUM_MASTERS), .NUM_REGS(NUM_REGS),
    .ADDR_W(ADDR_W), .TRUST_MASK(TRUST_MASK)
  ) decode_i (
    .addr(req_addr), .master(req_master),
    .tgt(tgt), .idx(idx), .trusted(trusted)
  );

  pguard_gate gate_i (
    .req_valid(req_valid), .req_write(req_write), .tgt(tgt),
    .trusted(trusted), .cur_sel(sel_val), .wdata(pctl_t'(req_wdata)),
    .commit_prv(commit_prv), .commit_pctl(commit_pctl), .reject(wr_reject)
  );

  pguard_store #(.NUM_MASTERS(NUM_MASTERS), .NUM_REGS(NUM_REGS)) store_i (
    .clk(clk), .rst_n(rst_n), .commit_prv(commit_prv),
    .commit_pctl(commit_pctl), .idx(idx), .wdata(req_wdata),
    .prv_q(prv_q), .pctl_q(pctl_q), .sel_val(sel_val)
  );

  pguard_priv #(.NUM_MASTERS(NUM_MASTERS)) priv_i (
    .prv_q(prv_q), .attr(mst_super_i), .eff(mst_super_eff_o)
  );

  assign wr_commit = commit_prv || commit_pctl;
  assign pctl_flat = pctl_q;

  always_comb begin
    unique case (tgt)
      TGT_PRIV:   rd_val = REG_W'(prv_q);
      TGT_PERIPH: rd_val = sel_val;
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_ack   <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_ack   <= req_valid;
      rsp_err   <= wr_reject;
      rsp_rdata <= (req_valid && !req_write) ? rd_val : '0;
    end
  end

endmodule

// File: rtl/pguard_checker.sv
module pguard_checker #(
  parameter int NUM_MASTERS = 4,
  parameter int NUM_REGS    = 10,
  parameter logic [NUM_MASTERS-1:0] TRUST_MASK = 'b0011,
  localparam int MID_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_write,
  input logic [MID_W-1:0]          req_master,
  input logic                      rsp_ack,
  input logic                      rsp_err,
  input logic [NUM_MASTERS-1:0]    prv_q,
  input logic [NUM_REGS*8-1:0]     pctl_flat,
  input logic                      wr_commit,
  input logic                      wr_reject,
  input logic [NUM_MASTERS-1:0]    mst_super_i,
  input logic [NUM_MASTERS-1:0]    mst_super_eff_o
);

  localparam logic [NUM_MASTERS-1:0] TRUSTED = TRUST_MASK | NUM_MASTERS'(1);

  assert_ack_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_ack);

  assert_no_ack_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_ack && !rsp_err);

  assert_err_with_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_ack);

  assert_untrusted_write_errs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !TRUSTED[req_master]) |=> rsp_err);

  assert_read_never_errs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> !rsp_err);

  assert_reject_no_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> $stable(pctl_flat) && $stable(prv_q));

  assert_commit_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_commit && wr_reject));

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_lock
    assert_lock_lo_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pctl_flat[g*8+3] |=> pctl_flat[g*8+3]);
    assert_lock_hi_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pctl_flat[g*8+7] |=> pctl_flat[g*8+7]);
  end

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_priv
    assert_priv_resolve_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mst_super_eff_o[m] == (prv_q[m] && mst_super_i[m]));
  end

endmodule

bind periph_guard pguard_checker #(
  .NUM_MASTERS(NUM_MASTERS), .NUM_REGS(NUM_REGS), .TRUST_MASK(TRUST_MASK)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_master(req_master), .rsp_ack(rsp_ack), .rsp_err(rsp_err),
  .prv_q(prv_q), .pctl_flat(pctl_flat), .wr_commit(wr_commit),
  .wr_reject(wr_reject), .mst_super_i(mst_super_i),
  .mst_super_eff_o(mst_super_eff_o)
);

// File: tb/periph_guard_tb.sv
module periph_guard_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_write = 1'b0;
  logic [3:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic [1:0] req_master = '0;
  logic [3:0] mst_super_i = '0;
  logic       rsp_ack;
  logic       rsp_err;
  logic [7:0] rsp_rdata;
  logic [3:0] mst_super_eff_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  int m_prv;
  int m_reg[10];
  int attr_pat = 0;
  int seed = 32'h1234_5678;

  always #4 clk = ~clk;  // 125 MHz

  periph_guard dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_master(req_master),
    .rsp_ack(rsp_ack), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .mst_super_i(mst_super_i), .mst_super_eff_o(mst_super_eff_o)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL [%s] %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic void model_reset();
    m_prv = 1;
    foreach (m_reg[i]) m_reg[i] = 0;
  endfunction

  function automatic int model_read(int a);
    if (a == 0) return m_prv;
    if (a >= 1 && a <= 10) return m_reg[a-1];
    return 0;
  endfunction

  // Returns 1 when the write is refused.
  function automatic bit model_write(int a, int d, int m);
    int cur;
    bit lo_bad, hi_bad;
    if (!(m == 0 || m == 1)) return 1;
    if (a == 0) begin
      m_prv = d % 16;
      return 0;
    end
    if (a > 10) return 1;
    cur = m_reg[a-1];
    lo_bad = ((cur / 8) % 2 == 1) && ((cur % 16) != (d % 16));
    hi_bad = ((cur / 128) == 1) && ((cur / 16) != (d / 16));
    if (lo_bad || hi_bad) return 1;
    m_reg[a-1] = d;
    return 0;
  endfunction

  task automatic do_req(input bit v, input bit w, input int a, input int d,
                        input int m, input string tag, output bit got_err);
    bit exp_err = 0;
    int exp_rd = 0;
    int exp_eff;
    if (v) begin
      if (w) exp_err = model_write(a, d, m);
      else   exp_rd  = model_read(a);
    end
    req_valid   = v;
    req_write   = w;
    req_addr    = a[3:0];
    req_wdata   = d[7:0];
    req_master  = m[1:0];
    mst_super_i = attr_pat[3:0];
    attr_pat    = (attr_pat + 5) % 16;
    @(negedge clk);
    exp_eff = m_prv & int'(mst_super_i);
    check(rsp_ack == v, "R2", "ack", rsp_ack, v);
    check(rsp_err == exp_err, tag, "err", rsp_err, exp_err);
    check(int'(rsp_rdata) == exp_rd, tag, "rdata", rsp_rdata, exp_rd);
    check(int'(mst_super_eff_o) == exp_eff, "R10", "eff", mst_super_eff_o, exp_eff);
    got_err = rsp_err;
  endtask

  task automatic wr(input int a, input int d, input int m, input string tag,
                    output bit e);
    do_req(1, 1, a, d, m, tag, e);
  endtask

  task automatic rd(input int a, input int m, input string tag);
    bit e;
    do_req(1, 0, a, 0, m, tag, e);
  endtask

  task automatic apply_reset();
    req_valid = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    check(rsp_ack == 0 && rsp_err == 0, "R1", "resp during reset",
          {rsp_ack, rsp_err}, 0);
    model_reset();
    rst_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL [R2] watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit e;
    model_reset();
    repeat (3) @(negedge clk);
    apply_reset();

    // R1: reset values
    for (int a = 0; a <= 10; a++) rd(a, 0, "R1");

    // R2: idle cycles
    do_req(0, 0, 0, 0, 0, "R2", e);
    do_req(0, 1, 3, 8'hFF, 0, "R2", e);

    // R5: trusted write with field layout
    wr(4, 8'h25, 0, "R5", e);
    check(e == 0, "R5", "trusted write accepted", e, 0);
    rd(4, 2, "R5");
    wr(10, 8'h63, 1, "R5", e);
    rd(10, 3, "R5");

    // R4: untrusted writes refused
    wr(4, 8'h11, 2, "R4", e);
    check(e == 1, "R4", "untrusted write err", e, 1);
    wr(0, 8'h0F, 3, "R4", e);
    check(e == 1, "R4", "untrusted priv write err", e, 1);
    rd(4, 3, "R3");
    rd(0, 2, "R3");

    // R12: privilege register width
    wr(0, 8'hFF, 1, "R12", e);
    rd(0, 0, "R12");
    do_req(0, 0, 0, 0, 0, "R10", e);
    wr(0, 8'hA6, 0, "R12", e);
    rd(0, 1, "R12");

    // R8: lock and code set together
    wr(6, 8'h0A, 0, "R8", e);
    check(e == 0, "R8", "lock+code write accepted", e, 0);
    rd(6, 0, "R8");

    // R6: locked lower half refuses change
    wr(6, 8'h0B, 0, "R6", e);
    check(e == 1, "R6", "locked code change err", e, 1);
    wr(6, 8'h02, 1, "R6", e);
    check(e == 1, "R6", "lock clear err", e, 1);
    rd(6, 0, "R6");

    // R7: unlocked half still writable
    wr(6, 8'h3A, 0, "R7", e);
    check(e == 0, "R7", "upper half write accepted", e, 0);
    rd(6, 0, "R7");

    // R9: lock holds across many attempts
    for (int k = 0; k < 24; k++) begin
      wr(6, ((k * 37) % 256) ^ 8'h01, k % 2, "R9", e);
    end
    rd(6, 0, "R9");

    // Upper lock, same-cycle effect, then refusal
    wr(6, 8'hDA, 0, "R8", e);
    check(e == 0, "R8", "upper lock set accepted", e, 0);
    wr(6, 8'hEA, 0, "R6", e);
    check(e == 1, "R6", "upper locked change err", e, 1);
    rd(6, 0, "R6");

    // R11: unmapped addresses
    wr(12, 8'h55, 0, "R11", e);
    check(e == 1, "R11", "unmapped write err", e, 1);
    rd(15, 0, "R11");
    rd(11, 3, "R11");

    // R9: reset clears locks
    apply_reset();
    rd(6, 0, "R9");
    wr(6, 8'h07, 0, "R9", e);
    check(e == 0, "R9", "write after reset accepted", e, 0);
    rd(6, 0, "R9");
    rd(0, 0, "R1");

    // Mixed sweep against the reference model
    for (int k = 0; k < 400; k++) begin
      int a, d, m, w, v;
      seed = seed * 1103515245 + 12345;
      v = ((seed >>> 8) % 8 != 0) ? 1 : 0;
      w = (seed >>> 12) & 1;
      a = (seed >>> 16) & 15;
      m = (seed >>> 20) & 3;
      seed = seed * 1103515245 + 12345;
      d = (seed >>> 10) & 255;
      do_req(v[0], w[0], a, d, m, "R6", e);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule